// File: doc/BRIEF.md
# Weighted Windowed Band Energy Detector

This block reduces a stream of tagged wavelet coefficients to one detection score per fixed window and flags a seizure when that score is too high. Each coefficient arrives with a band index and a valid bit. The block only listens while an upstream warning input is high. For every band it keeps a running sum of coefficient magnitudes and a count of how many coefficients arrived. When the window ends it forms a cheap average for each band. This average is the magnitude sum shifted right by the floor of log2 of that band's count, so no divider is needed.

The averages of the bands chosen by a per-patient select mask are each multiplied by an 8-bit per-band weight and added together. The total is presented with a one-cycle strobe. A seizure flag compares that total against a programmable threshold and holds its value until the next result. The band mask, the weights, the window size (as log2 of the coefficient count) and the threshold are static configuration inputs driven by a register bank outside the block.

Top module: `bandScoreDetect`

## Requirements
- R1: After reset, `scoreValid` and `seizureFlag` are 0 and `score` is 0.
- R2: A window holds 2^`cfgWinLog2` accepted coefficients. A coefficient is accepted when `enable`, `coefValid` and an in-range band index are all present at a clock edge. `scoreValid` goes high one clock after the edge that accepts the last coefficient of the window, and stays high for exactly one cycle. Before that it stays low.
- R3: Each band's average is the sum of its coefficient magnitudes shifted right by floor(log2(count)), where count is the number of that band's coefficients in the window. A band with no coefficients averages 0.
- R4: `score` is the sum, over the selected bands, of average × weight. The weight of band b is `cfgWeights[8b+7:8b]`, unsigned, and values up to 255 are used without loss.
- R5: Bit b of `cfgMask` selects band b. A band whose mask bit is 0 adds nothing to `score`, and an all-zero mask gives a score of 0.
- R6: `seizureFlag` is updated with each result to 1 exactly when `score` is strictly greater than `cfgThresh` (a tie gives 0). Both the flag and `score` hold their values until the next result.
- R7: While `enable` is low, no coefficient is accepted, the partial window is discarded and `scoreValid` stays low. The next window starts from empty once `enable` returns.
- R8: Coefficients whose band index is 6 or above are ignored. They neither add to any band nor count toward the window length.
- R9: A coefficient accepted in the same cycle that a result is produced is the first coefficient of the next window.
- R10: Negative coefficients contribute their magnitude. This includes the most negative code, whose magnitude is 2^(COEF_W-1).
- R11: A `cfgWinLog2` value above `WIN_LOG2_MAX` is treated as `WIN_LOG2_MAX`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Warning flag from the monitoring stage; low discards the window |
| coefValid | input | 1 | Coefficient present this cycle |
| coefBand | input | $clog2(NUM_BANDS) | Band index of the coefficient |
| coefData | input | COEF_W | Signed coefficient value |
| cfgMask | input | NUM_BANDS | Band select mask |
| cfgWeights | input | NUM_BANDS*WEIGHT_W | Packed per-band unsigned weights, band 0 in the low bits |
| cfgWinLog2 | input | $clog2(WIN_LOG2_MAX+1) | log2 of the window length in coefficients |
| cfgThresh | input | SCORE_W | Seizure threshold |
| scoreValid | output | 1 | One-cycle strobe marking a new score |
| score | output | SCORE_W | Weighted detection score of the last window |
| seizureFlag | output | 1 | Score exceeded threshold in the last window |

## Verification
The bench builds the block with COEF_W = 12 and WIN_LOG2_MAX = 5, keeping six bands and 8-bit weights. Because the coefficient is only 12 bits wide, the most negative code (-2048) can be driven directly. The largest window is 32 coefficients, so the clamp of an oversized window selector and a full window of maximum-magnitude data at weight 255 both fit in a few dozen cycles. A window of one coefficient, and two coefficients arriving back to back around a result, test the close cycle.

// File: rtl/bsdPkg.sv
package bsdPkg;

  // Control strobes from the window controller to the datapath
  typedef struct packed {
    logic clear;   // discard all partial sums
    logic accept;  // a coefficient enters the window this cycle
    logic close;   // the window is complete: publish and restart
  } bsdStrobe_t;

endpackage

// File: rtl/bsdControl.sv
module bsdControl
  import bsdPkg::*;
#(
  parameter int NUM_BANDS    = 6,
  parameter int WIN_LOG2_MAX = 10,
  localparam int BAND_IDX_W  = $clog2(NUM_BANDS),
  localparam int WIN_SEL_W   = $clog2(WIN_LOG2_MAX + 1),
  localparam int CNT_W       = WIN_LOG2_MAX + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic                  coefValid,
  input  logic [BAND_IDX_W-1:0] coefBand,
  input  logic [WIN_SEL_W-1:0]  cfgWinLog2,
  output bsdStrobe_t            strobe
);

  localparam logic [WIN_SEL_W-1:0] MAX_SEL = WIN_SEL_W'(WIN_LOG2_MAX);

  logic [CNT_W-1:0]     totalCnt;
  logic [CNT_W-1:0]     nextCnt;
  logic [CNT_W-1:0]     winLen;
  logic [WIN_SEL_W-1:0] effLog2;
  logic                 closePending;
  logic                 bandOk;

  always_comb begin
    effLog2 = (cfgWinLog2 > MAX_SEL) ? MAX_SEL : cfgWinLog2;
    winLen  = CNT_W'(1) << effLog2;
    bandOk  = (int'(coefBand) < NUM_BANDS);

    strobe.clear  = ~enable;
    strobe.accept = enable & coefValid & bandOk;
    strobe.close  = enable & closePending;

    nextCnt = totalCnt + CNT_W'(strobe.accept);
  end

  // The window counter restarts when the last coefficient is accepted,
  // so a coefficient in the following (close) cycle opens a new window.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      totalCnt     <= '0;
      closePending <= 1'b0;
    end else if (!enable) begin
      totalCnt     <= '0;
      closePending <= 1'b0;
    end else if (strobe.accept && (nextCnt >= winLen)) begin
      totalCnt     <= '0;
      closePending <= 1'b1;
    end else begin
      totalCnt     <= nextCnt;
      closePending <= 1'b0;
    end
  end

endmodule

// File: rtl/bsdBandLane.sv
module bsdBandLane
  import bsdPkg::*;
#(
  parameter int BAND_ID      = 0,
  parameter int NUM_BANDS    = 6,
  parameter int COEF_W       = 16,
  parameter int WIN_LOG2_MAX = 10,
  localparam int BAND_IDX_W  = $clog2(NUM_BANDS),
  localparam int ACC_W       = COEF_W + WIN_LOG2_MAX,
  localparam int CNT_W       = WIN_LOG2_MAX + 1,
  localparam int SH_W        = $clog2(CNT_W)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bsdStrobe_t            strobe,
  input  logic [BAND_IDX_W-1:0] coefBand,
  input  logic [COEF_W-1:0]     coefMag,
  output logic [ACC_W-1:0]      avg
);

  logic [ACC_W-1:0] accSum;
  logic [CNT_W-1:0] accCnt;
  logic             hit;
  logic [SH_W-1:0]  shiftAmt;

  // Position of the highest set bit; zero for a count of zero or one
  function automatic logic [SH_W-1:0] floorLog2(input logic [CNT_W-1:0] val);
    logic [SH_W-1:0] pos;
    pos = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (val[i]) pos = SH_W'(i);
    end
    return pos;
  endfunction

  assign hit = strobe.accept && (coefBand == BAND_IDX_W'(BAND_ID));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accSum <= '0;
      accCnt <= '0;
    end else if (strobe.clear) begin
      accSum <= '0;
      accCnt <= '0;
    end else if (strobe.close) begin
      accSum <= hit ? ACC_W'(coefMag) : '0;
      accCnt <= hit ? CNT_W'(1) : '0;
    end else if (hit) begin
      accSum <= accSum + ACC_W'(coefMag);
      accCnt <= accCnt + CNT_W'(1);
    end
  end

  always_comb begin
    shiftAmt = floorLog2(accCnt);
    avg      = accSum >> shiftAmt;
  end

endmodule

// File: rtl/bsdDatapath.sv
module bsdDatapath
  import bsdPkg::*;
#(
  parameter int NUM_BANDS    = 6,
  parameter int COEF_W       = 16,
  parameter int WEIGHT_W     = 8,
  parameter int WIN_LOG2_MAX = 10,
  localparam int BAND_IDX_W  = $clog2(NUM_BANDS),
  localparam int ACC_W       = COEF_W + WIN_LOG2_MAX,
  localparam int PROD_W      = ACC_W + WEIGHT_W,
  localparam int SCORE_W     = PROD_W + $clog2(NUM_BANDS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  bsdStrobe_t                    strobe,
  input  logic [BAND_IDX_W-1:0]         coefBand,
  input  logic signed [COEF_W-1:0]      coefData,
  input  logic [NUM_BANDS-1:0]          cfgMask,
  input  logic [NUM_BANDS*WEIGHT_W-1:0] cfgWeights,
  input  logic [SCORE_W-1:0]            cfgThresh,
  output logic                          scoreValid,
  output logic [SCORE_W-1:0]            score,
  output logic                          seizureFlag
);

  logic [COEF_W-1:0]  coefMag;
  logic [ACC_W-1:0]   avgArr [NUM_BANDS];
  logic [SCORE_W-1:0] sumNext;

  // Two's complement magnitude; the most negative code maps to 2^(COEF_W-1)
  assign coefMag = coefData[COEF_W-1] ? (~coefData + 1'b1) : coefData;

  for (genvar b = 0; b < NUM_BANDS; b++) begin : gLane
    bsdBandLane #(
      .BAND_ID     (b),
      .NUM_BANDS   (NUM_BANDS),
      .COEF_W      (COEF_W),
      .WIN_LOG2_MAX(WIN_LOG2_MAX)
    ) i_lane (
      .clk     (clk),
      .rstN    (rstN),
      .strobe  (strobe),
      .coefBand(coefBand),
      .coefMag (coefMag),
      .avg     (avgArr[b])
    );
  end

  always_comb begin
    sumNext = '0;
    for (int b = 0; b < NUM_BANDS; b++) begin
      if (cfgMask[b]) begin
        sumNext = sumNext + SCORE_W'(avgArr[b])
                          * SCORE_W'(cfgWeights[b*WEIGHT_W +: WEIGHT_W]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scoreValid  <= 1'b0;
      score       <= '0;
      seizureFlag <= 1'b0;
    end else if (strobe.close) begin
      scoreValid  <= 1'b1;
      score       <= sumNext;
      seizureFlag <= (sumNext > cfgThresh);
    end else begin
      scoreValid  <= 1'b0;
    end
  end

endmodule

// File: rtl/bandScoreDetect.sv
module bandScoreDetect
  import bsdPkg::*;
#(
  parameter int NUM_BANDS    = 6,
  parameter int COEF_W       = 16,
  parameter int WEIGHT_W     = 8,
  parameter int WIN_LOG2_MAX = 10,
  localparam int BAND_IDX_W  = $clog2(NUM_BANDS),
  localparam int WIN_SEL_W   = $clog2(WIN_LOG2_MAX + 1),
  localparam int SCORE_W     = COEF_W + WIN_LOG2_MAX + WEIGHT_W + $clog2(NUM_BANDS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          enable,
  input  logic                          coefValid,
  input  logic [BAND_IDX_W-1:0]         coefBand,
  input  logic signed [COEF_W-1:0]      coefData,
  input  logic [NUM_BANDS-1:0]          cfgMask,
  input  logic [NUM_BANDS*WEIGHT_W-1:0] cfgWeights,
  input  logic [WIN_SEL_W-1:0]          cfgWinLog2,
  input  logic [SCORE_W-1:0]            cfgThresh,
  output logic                          scoreValid,
  output logic [SCORE_W-1:0]            score,
  output logic                          seizureFlag
);

  bsdStrobe_t strobe;

  bsdControl #(
    .NUM_BANDS   (NUM_BANDS),
    .WIN_LOG2_MAX(WIN_LOG2_MAX)
  ) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .coefValid (coefValid),
    .coefBand  (coefBand),
    .cfgWinLog2(cfgWinLog2),
    .strobe    (strobe)
  );

  bsdDatapath #(
    .NUM_BANDS   (NUM_BANDS),
    .COEF_W      (COEF_W),
    .WEIGHT_W    (WEIGHT_W),
    .WIN_LOG2_MAX(WIN_LOG2_MAX)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .coefBand   (coefBand),
    .coefData   (coefData),
    .cfgMask    (cfgMask),
    .cfgWeights (cfgWeights),
    .cfgThresh  (cfgThresh),
    .scoreValid (scoreValid),
    .score      (score),
    .seizureFlag(seizureFlag)
  );

endmodule

// File: rtl/bsdChecker.sv
module bsdChecker #(
  parameter int NUM_BANDS = 6,
  parameter int SCORE_W   = 33
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 enable,
  input logic [NUM_BANDS-1:0] cfgMask,
  input logic [SCORE_W-1:0]   cfgThresh,
  input logic                 scoreValid,
  input logic [SCORE_W-1:0]   score,
  input logic                 seizureFlag
);

  // R7
  no_result_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !scoreValid);

  // R6
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !scoreValid |-> $stable(seizureFlag));

  // R6
  score_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !scoreValid |-> $stable(score));

  // R6
  strict_compare_chk: assert property (@(posedge clk) disable iff (!rstN)
    scoreValid |-> (seizureFlag == (score > $past(cfgThresh))));

  // R5
  empty_mask_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (scoreValid && ($past(cfgMask) == '0)) |-> (score == '0));

endmodule

bind bandScoreDetect bsdChecker #(
  .NUM_BANDS(NUM_BANDS),
  .SCORE_W  (SCORE_W)
) i_bsdChecker (.*);

// File: tb/test_bandScoreDetect.sv
module test_bandScoreDetect;

  localparam int NB = 6;
  localparam int CW = 12;
  localparam int WW = 8;
  localparam int WL = 5;
  localparam int SW = CW + WL + WW + $clog2(NB);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic             coefValid = 1'b0;
  logic [2:0]       coefBand = '0;
  logic [CW-1:0]    coefData = '0;
  logic [NB-1:0]    cfgMask = '1;
  logic [NB*WW-1:0] cfgWeights = '0;
  logic [2:0]       cfgWinLog2 = 3'd2;
  logic [SW-1:0]    cfgThresh = '0;
  logic             scoreValid;
  logic [SW-1:0]    score;
  logic             seizureFlag;

  int compared = 0;
  int mismatched = 0;
  longint mSum [NB];
  int     mCnt [NB];

  always #5 clk = ~clk;

  bandScoreDetect #(
    .NUM_BANDS(NB), .COEF_W(CW), .WEIGHT_W(WW), .WIN_LOG2_MAX(WL)
  ) i_bandScoreDetect (
    .clk(clk), .rstN(rstN), .enable(enable), .coefValid(coefValid),
    .coefBand(coefBand), .coefData(coefData), .cfgMask(cfgMask),
    .cfgWeights(cfgWeights), .cfgWinLog2(cfgWinLog2), .cfgThresh(cfgThresh),
    .scoreValid(scoreValid), .score(score), .seizureFlag(seizureFlag)
  );

  task automatic checkVal(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int b = 0; b < NB; b++) begin
      mSum[b] = 0;
      mCnt[b] = 0;
    end
  endtask

  task automatic setWeights(input int base, input bit flat);
    for (int b = 0; b < NB; b++) cfgWeights[b*WW +: WW] = WW'(flat ? base : base + b);
  endtask

  // Drive one coefficient for one cycle; returns at the next falling edge
  task automatic sendCoef(input int band, input int val);
    coefValid = 1'b1;
    coefBand  = 3'(band);
    coefData  = CW'(val);
    @(negedge clk);
    coefValid = 1'b0;
    if (band < NB && enable) begin
      mSum[band] += (val < 0) ? -val : val;
      mCnt[band] += 1;
    end
  endtask

  function automatic longint expScore();
    longint total = 0;
    for (int b = 0; b < NB; b++) begin
      if (cfgMask[b] && mCnt[b] > 0) begin
        int lg = 0;
        int c = mCnt[b];
        while (c > 1) begin
          c = c >> 1;
          lg++;
        end
        total += (mSum[b] >>> lg) * longint'(cfgWeights[b*WW +: WW]);
      end
    end
    return total;
  endfunction

  // Called right after the last coefficient of a window was accepted
  task automatic expectResult(input string req);
    longint e;
    e = expScore();
    @(negedge clk);
    checkVal({req, " strobe"}, longint'(scoreValid), 1);
    checkVal({req, " score"}, longint'(score), e);
    checkVal({req, " flag"}, longint'(seizureFlag), (e > longint'(cfgThresh)) ? 1 : 0);
    @(negedge clk);
    checkVal({req, " strobe width"}, longint'(scoreValid), 0);
    modelClear();
  endtask

  task automatic testReset();
    checkVal("R1 strobe", longint'(scoreValid), 0);
    checkVal("R1 score", longint'(score), 0);
    checkVal("R1 flag", longint'(seizureFlag), 0);
  endtask

  task automatic testBasic();
    cfgWinLog2 = 3'd2; cfgMask = '1; setWeights(1, 0); cfgThresh = SW'(68);
    modelClear();
    sendCoef(0, 10); sendCoef(0, -6); sendCoef(1, 20);
    checkVal("R2 early strobe", longint'(scoreValid), 0);
    sendCoef(2, -7);
    checkVal("R2 strobe at accept", longint'(scoreValid), 0);
    expectResult("R2 R3 R4 basic");
    checkVal("R4 hand value", longint'(score), 69);
  endtask

  task automatic testMask();
    cfgWinLog2 = 3'd2; cfgMask = 6'b111101; setWeights(1, 0); cfgThresh = SW'(68);
    sendCoef(0, 10); sendCoef(0, -6); sendCoef(1, 20); sendCoef(2, -7);
    expectResult("R5 band1 masked");
    checkVal("R5 hand value", longint'(score), 29);
    cfgThresh = SW'(29);
    sendCoef(0, 10); sendCoef(0, -6); sendCoef(1, 20); sendCoef(2, -7);
    expectResult("R6 tie");
    checkVal("R6 tie flag", longint'(seizureFlag), 0);
    cfgThresh = SW'(28);
    sendCoef(0, 10); sendCoef(0, -6); sendCoef(1, 20); sendCoef(2, -7);
    expectResult("R6 above");
    cfgThresh = SW'(1000);
    repeat (3) @(negedge clk);
    checkVal("R6 flag holds", longint'(seizureFlag), 1);
    checkVal("R6 score holds", longint'(score), 29);
    cfgMask = '0;
    sendCoef(0, 10); sendCoef(3, 5); sendCoef(1, 20); sendCoef(2, -7);
    expectResult("R5 empty mask");
    cfgMask = '1;
  endtask

  task automatic testQuasiAvg();
    cfgWinLog2 = 3'd3; setWeights(1, 0); cfgThresh = SW'(21);
    sendCoef(0, 4); sendCoef(3, -5); sendCoef(0, 4); sendCoef(3, 7);
    sendCoef(3, 1); sendCoef(0, 4); sendCoef(3, -2); sendCoef(3, 3);
    expectResult("R3 R10 odd counts");
    checkVal("R3 hand value", longint'(score), 22);
  endtask

  task automatic testBadBand();
    cfgWinLog2 = 3'd2; setWeights(2, 0); cfgThresh = SW'(0);
    sendCoef(6, 100); sendCoef(0, 1); sendCoef(7, 50); sendCoef(1, 2); sendCoef(2, 3);
    repeat (2) begin
      @(negedge clk);
      checkVal("R8 out-of-range not counted", longint'(scoreValid), 0);
    end
    sendCoef(3, 4);
    expectResult("R8 out-of-range ignored");
  endtask

  task automatic testEnableDrop();
    cfgWinLog2 = 3'd2; setWeights(1, 0); cfgThresh = SW'(0);
    sendCoef(0, 500); sendCoef(1, 500);
    enable = 1'b0;
    sendCoef(2, 900); sendCoef(2, 900);
    repeat (2) begin
      @(negedge clk);
      checkVal("R7 no result while disabled", longint'(scoreValid), 0);
    end
    enable = 1'b1;
    modelClear();
    sendCoef(4, 3); sendCoef(5, -8);
    @(negedge clk);
    checkVal("R7 partial discarded", longint'(scoreValid), 0);
    sendCoef(4, 5); sendCoef(0, 1);
    expectResult("R7 fresh window");
  endtask

  task automatic testBackToBack();
    cfgWinLog2 = 3'd1; setWeights(1, 0); cfgThresh = SW'(10);
    sendCoef(0, 8); sendCoef(0, 8); sendCoef(3, -5);
    checkVal("R9 first strobe", longint'(scoreValid), 1);
    checkVal("R9 first score", longint'(score), 8);
    checkVal("R9 first flag", longint'(seizureFlag), 0);
    sendCoef(3, 9);
    checkVal("R9 strobe gap", longint'(scoreValid), 0);
    @(negedge clk);
    checkVal("R9 second strobe", longint'(scoreValid), 1);
    checkVal("R9 second score", longint'(score), 28);
    checkVal("R9 second flag", longint'(seizureFlag), 1);
    modelClear();
  endtask

  task automatic testMostNeg();
    cfgWinLog2 = 3'd0; setWeights(255, 1); cfgThresh = SW'(522239);
    sendCoef(4, -2048);
    expectResult("R10 most negative");
    checkVal("R10 hand value", longint'(score), 522240);
  endtask

  task automatic testClamp();
    cfgWinLog2 = 3'd7; setWeights(255, 1); cfgThresh = SW'(0);
    for (int i = 0; i < 31; i++) sendCoef(2, (i % 2 == 0) ? 2047 : -2047);
    repeat (2) begin
      @(negedge clk);
      checkVal("R11 clamp not early", longint'(scoreValid), 0);
    end
    sendCoef(2, -2047);
    expectResult("R11 R4 clamp to 32");
    checkVal("R4 max weight", longint'(score), 2047 * 255);
  endtask

  initial begin
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    enable = 1'b1;
    @(negedge clk);
    testBasic();
    testMask();
    testQuasiAvg();
    testBadBand();
    testEnableDrop();
    testBackToBack();
    testMostNeg();
    testClamp();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule